// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter inside a small microcontroller. Software reaches it through two byte registers on a narrow bus. A control register holds a channel number, a ladder power bit and a completion flag. A data register, one address above it, returns the last converted value and cannot be written. The analog pieces sit outside the block: the resistor ladder, the input multiplexer and the comparator. The block drives the channel number, the ladder power bit and the current trial code toward them, and it reads back a single comparator bit that is high when the selected input is at or above the trial code.

A conversion starts when software writes the control register with the completion flag cleared. A state machine then resolves the eight result bits, most significant first. Each bit has a fixed slot of cycles. The machine has five states:

- IDLE waits for a start.
- SET raises the trial bit.
- WAIT lets the ladder settle.
- DECIDE keeps or drops the trial bit using the comparator.
- TAIL fills the idle cycles left in the window.

The transitions are:

- IDLE to SET on a start.
- SET to WAIT, or straight to DECIDE when a slot has only two cycles.
- WAIT to DECIDE on the last cycle of the slot.
- DECIDE to SET while bits remain, and to TAIL after the last bit.
- TAIL to IDLE on the last cycle of the window.
- Any state to SET on a new start.

On the last window cycle the result is copied into the data register, the flag is set and an interrupt request is latched. The request stays set until it is acknowledged.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the control register reads 0x08: flag bit 3 is 1, channel bits 2..0 are 0 and ladder bit 4 is 0. The data register reads 0x00, `irq` is 0, `ladder_en` is 0 and `chan_sel` is 0.
- R2: The control register is at offset 0 and reads as {3'b000, ladder bit 4, flag bit 3, channel bits 2..0}. `chan_sel` and `ladder_en` follow the written channel and ladder fields from the cycle after the write.
- R3: A control write with bit 3 = 0 starts a conversion. From the next cycle the flag reads 0 until the conversion completes.
- R4: A control write with bit 3 = 1 while idle starts nothing: the flag stays 1 and `irq` stays 0.
- R5: The flag returns to 1 and `irq` rises exactly 50 clock cycles after the clock edge that took the starting write.
- R6: The result is the largest 8-bit code that the comparator judges at or below the selected input. With an ideal comparator this equals the input value.
- R7: Trial j (j = 0..7) owns busy cycles 6j..6j+5. During busy cycle 6j+3, `dac_code` shows the already decided upper bits, bit 7-j set to 1 and all lower bits 0. The trial bit is decided at the end of cycle 6j+5, and cycles 48 and 49 are idle.
- R8: The data register is at offset 1. It holds its previous value while a conversion runs and changes only on completion.
- R9: `irq` stays 1 until a cycle with `irq_ack` high, and it reads 0 in the cycle after that.
- R10: A start write during a conversion restarts it. Completion then comes 50 cycles after the latest start, and nothing completes at the earlier due cycle.
- R11: A control write with bit 3 = 1 during a conversion updates the channel and ladder fields but neither stops nor restarts the conversion. The flag keeps reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per period |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Register offset: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cmp_in | input | 1 | Comparator: 1 when input is at or above `dac_code` |
| irq_ack | input | 1 | Clears the interrupt request |
| chan_sel | output | 3 | Selected analog channel |
| ladder_en | output | 1 | Connects the reference ladder |
| dac_code | output | 8 | Current trial code toward the ladder |
| irq | output | 1 | Latched conversion-complete request |

## Verification
The conversion is tried with input codes at the two rails (0x00, 0xFF), on both sides of mid-scale (0x80, 0x7F), and with alternating bit patterns (0x55, 0xA5, 0x3C, 0xC3, 0x6A), each placed on a different channel.

- The rail codes show whether a trial bit is dropped or kept in every slot.
- The codes on either side of mid-scale show whether the top bit is decided first and whether it is correctly kept or rejected.
- The alternating patterns show whether each decision lands on its own bit position.
- Changing the channel while the other inputs hold different values shows whether the channel select is routed to the front end.

Restart and flag-only writes issued in the middle of a conversion show whether the 50-cycle window is counted from the latest start. An idle write with the flag set shows whether a write alone can start a conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET,
        ST_WAIT,
        ST_DECIDE,
        ST_TAIL
    } sar_state_e;

endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int RES_W       = 8,
    parameter int CONV_CYCLES = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int SLOT  = (CONV_CYCLES - 1) / RES_W;
    localparam int CNT_W = $clog2(CONV_CYCLES);
    localparam int SP_W  = $clog2(SLOT + 1);
    localparam int BIT_W = $clog2(RES_W);

    sar_state_e       state_q, state_d;
    logic [CNT_W-1:0] cyc_q;
    logic [SP_W-1:0]  slot_q;
    logic [BIT_W-1:0] bit_q;
    logic [RES_W-1:0] trial_q;
    logic             last_cyc;

    assign last_cyc = (cyc_q == CNT_W'(CONV_CYCLES - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_SET;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_SET:    state_d = (SLOT > 2) ? ST_WAIT : ST_DECIDE;
                ST_WAIT:   state_d = (slot_q == SP_W'(SLOT - 2)) ? ST_DECIDE : ST_WAIT;
                ST_DECIDE: state_d = (bit_q == '0) ? ST_TAIL : ST_SET;
                ST_TAIL:   state_d = last_cyc ? ST_IDLE : ST_TAIL;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath: cycle and slot counters, trial code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            slot_q  <= '0;
            bit_q   <= BIT_W'(RES_W - 1);
            trial_q <= '0;
        end else if (start_i) begin
            cyc_q   <= '0;
            slot_q  <= '0;
            bit_q   <= BIT_W'(RES_W - 1);
            trial_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_SET: begin
                    trial_q[bit_q] <= 1'b1;
                    cyc_q          <= cyc_q + 1'b1;
                    slot_q         <= slot_q + 1'b1;
                end
                ST_WAIT: begin
                    cyc_q  <= cyc_q + 1'b1;
                    slot_q <= slot_q + 1'b1;
                end
                ST_DECIDE: begin
                    trial_q[bit_q] <= cmp_i;
                    cyc_q          <= cyc_q + 1'b1;
                    slot_q         <= '0;
                    if (bit_q != '0) bit_q <= bit_q - 1'b1;
                end
                ST_TAIL: cyc_q <= last_cyc ? '0 : cyc_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        trial_o = trial_q;
        busy_o  = (state_q != ST_IDLE);
        done_o  = (state_q == ST_TAIL) && last_cyc && !start_i;
    end

    // R5: the window counter never runs past the conversion length
    p_cyc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (32'(cyc_q) < CONV_CYCLES));

    // R7: each trial slot begins on its own evenly spaced cycle
    p_slot_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SET) |-> ((32'(RES_W - 1) - 32'(bit_q)) * 32'(SLOT) == 32'(cyc_q)));

    // R7: a trial bit is raised in the cycle after SET
    p_trial_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SET && !start_i) |=> trial_q[bit_q]);

endmodule

// File: rtl/sar_ctrl_regs.sv
module sar_ctrl_regs #(
    parameter int ADDR_W   = 1,
    parameter int CTRL_OFS = 0,
    parameter int CHAN_W   = 3,
    parameter int RES_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [RES_W-1:0]  bus_wdata,
    output logic [RES_W-1:0]  bus_rdata,
    input  logic              done_i,
    input  logic [RES_W-1:0]  result_i,
    input  logic              irq_ack,
    output logic              start_o,
    output logic [CHAN_W-1:0] chan_o,
    output logic              ladder_o,
    output logic              end_o,
    output logic              irq_o
);

    localparam int END_BIT = CHAN_W;
    localparam int LAD_BIT = CHAN_W + 1;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(CTRL_OFS + 1);

    logic [CHAN_W-1:0] chan_q;
    logic              ladder_q;
    logic              end_q;
    logic              irq_q;
    logic [RES_W-1:0]  result_q;
    logic              ctrl_wr;
    logic [RES_W-1:0]  ctrl_rd;

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_A);
    assign start_o = ctrl_wr && !bus_wdata[END_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q   <= '0;
            ladder_q <= 1'b0;
        end else if (ctrl_wr) begin
            chan_q   <= bus_wdata[CHAN_W-1:0];
            ladder_q <= bus_wdata[LAD_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       end_q <= 1'b1;
        else if (start_o) end_q <= 1'b0;
        else if (done_i)  end_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (done_i)  irq_q <= 1'b1;
        else if (irq_ack) irq_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      result_q <= '0;
        else if (done_i) result_q <= result_i;
    end

    always_comb begin
        ctrl_rd             = '0;
        ctrl_rd[CHAN_W-1:0] = chan_q;
        ctrl_rd[END_BIT]    = end_q;
        ctrl_rd[LAD_BIT]    = ladder_q;
        if (bus_addr == CTRL_A)      bus_rdata = ctrl_rd;
        else if (bus_addr == DATA_A) bus_rdata = result_q;
        else                         bus_rdata = '0;
    end

    assign chan_o   = chan_q;
    assign ladder_o = ladder_q;
    assign end_o    = end_q;
    assign irq_o    = irq_q;

    // R3: a start clears the completion flag
    p_start_clears_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !end_q);

    // R5: completion sets the flag and the request
    p_done_sets_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !start_o) |=> (end_q && irq_q));

    // R8: the result register moves only on completion
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(result_q));

    // R9: the request holds until acknowledged
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_ack) |=> irq_q);

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
    parameter int ADDR_W      = 1,
    parameter int CTRL_OFS    = 0,
    parameter int CHAN_W      = 3,
    parameter int RES_W       = 8,
    parameter int CONV_CYCLES = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [RES_W-1:0]  bus_wdata,
    output logic [RES_W-1:0]  bus_rdata,
    input  logic              cmp_in,
    input  logic              irq_ack,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              ladder_en,
    output logic [RES_W-1:0]  dac_code,
    output logic              irq
);

    logic start;
    logic busy;
    logic done;
    logic end_flag;

    sar_ctrl_regs #(
        .ADDR_W  (ADDR_W),
        .CTRL_OFS(CTRL_OFS),
        .CHAN_W  (CHAN_W),
        .RES_W   (RES_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .done_i   (done),
        .result_i (dac_code),
        .irq_ack  (irq_ack),
        .start_o  (start),
        .chan_o   (chan_sel),
        .ladder_o (ladder_en),
        .end_o    (end_flag),
        .irq_o    (irq)
    );

    sar_sequencer #(
        .RES_W      (RES_W),
        .CONV_CYCLES(CONV_CYCLES)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .cmp_i  (cmp_in),
        .trial_o(dac_code),
        .busy_o (busy),
        .done_o (done)
    );

    // R3: the flag reads 0 whenever the sequencer is busy
    p_end_low_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !end_flag);

    // R4: an idle sequencer never produces a completion
    p_no_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !done);

endmodule

// File: tb/tb_sar_adc_ctrl.sv
`timescale 1ns/100ps
module tb_sar_adc_ctrl;

    localparam int CONV = 50;
    localparam int SLOT = 6;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [0:0] bus_addr = 1'b1;
    logic       bus_wr = 0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cmp_in;
    logic       irq_ack = 0;
    logic [2:0] chan_sel;
    logic       ladder_en;
    logic [7:0] dac_code;
    logic       irq;

    logic [7:0] vin [8];
    int cnt = 0;
    int n_chk = 0;
    int n_bad = 0;

    typedef struct { logic [7:0] val; int due; } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 1;

    assign cmp_in = (vin[chan_sel] >= dac_code);

    sar_adc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
        .irq_ack(irq_ack), .chan_sel(chan_sel), .ladder_en(ladder_en),
        .dac_code(dac_code), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cnt);
        end
    endtask

    // called just after a negedge; restores the data offset afterwards
    task automatic rd(input logic a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = 1'b1;
    endtask

    task automatic wr_ctrl(input logic [7:0] v, output int wc);
        @(negedge clk);
        bus_addr = 1'b0; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 1'b1;
        wc = cnt;
    endtask

    task automatic wait_cnt(input int n);
        while (cnt < n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_trial(input logic [7:0] v, input int j);
        logic [7:0] hi;
        hi = 8'hFF << (8 - j);
        if (j == 0) hi = 8'h00;
        return (v & hi) | (8'h80 >> j);
    endfunction

    task automatic ack_irq();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        #1;
        chk(irq == 1'b0, "R9 ack clears irq", irq, 0);
    endtask

    // full conversion with trial-code and flag checks
    task automatic run_conv(input logic [2:0] ch, input logic [7:0] v, input logic [7:0] prev);
        int wc;
        logic [7:0] r;
        vin[ch] = v;
        wr_ctrl({3'b000, 1'b1, 1'b0, ch}, wc);
        q.push_back('{val: v, due: wc + CONV});
        #1;
        chk(ladder_en == 1'b1 && chan_sel == ch, "R2 front-end outputs", {ladder_en, chan_sel}, {1'b1, ch});
        rd(1'b0, r);
        chk(r[3] == 1'b0, "R3 flag low while busy", r, {4'b0001, 1'b0, ch});
        for (int j = 0; j < 8; j++) begin
            wait_cnt(wc + SLOT * j + 3);
            #1;
            chk(dac_code == exp_trial(v, j), "R7 trial code", dac_code, exp_trial(v, j));
            if (j == 4) begin
                rd(1'b1, r);
                chk(r == prev, "R8 data holds previous", r, prev);
            end
        end
        wait_cnt(wc + CONV - 1);
        rd(1'b0, r);
        chk(r[3] == 1'b0, "R5 flag still low one cycle before", r[3], 0);
        wait_cnt(wc + CONV + 1);
        rd(1'b0, r);
        chk(r[3] == 1'b1, "R5 flag high after window", r[3], 1);
        chk(irq == 1'b1, "R9 irq held", irq, 1);
        repeat (5) @(negedge clk);
        #1;
        chk(irq == 1'b1, "R9 irq held without ack", irq, 1);
        ack_irq();
    endtask

    // scoreboard monitor
    initial begin
        logic prev_irq;
        prev_irq = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && irq && !prev_irq) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R4 unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(cnt == e.due, "R5 completion cycle", cnt, e.due);
                    chk(bus_addr == 1'b1 && bus_rdata == e.val, "R6 result value", bus_rdata, e.val);
                end
            end
            prev_irq = irq;
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int wa, wb;
        for (int i = 0; i < 8; i++) vin[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(1'b0, r);
        chk(r == 8'h08, "R1 control reset value", r, 8'h08);
        rd(1'b1, r);
        chk(r == 8'h00, "R1 data reset value", r, 8'h00);
        chk(irq == 0 && ladder_en == 0 && chan_sel == 0, "R1 outputs after reset",
            {irq, ladder_en, chan_sel}, 0);

        // R2 / R4: flag-set write while idle
        wr_ctrl(8'h1B, wa);
        rd(1'b0, r);
        chk(r == 8'h1B, "R2 control read layout", r, 8'h1B);
        chk(chan_sel == 3'd3 && ladder_en == 1'b1, "R2 outputs follow write",
            {ladder_en, chan_sel}, 4'hB);
        wait_cnt(wa + 60);
        rd(1'b0, r);
        chk(r[3] == 1'b1 && irq == 1'b0, "R4 no start from flag-set write", {r[3], irq}, 2'b10);

        // R6 patterns across channels
        run_conv(3'd3, 8'hA5, 8'h00);
        run_conv(3'd0, 8'h00, 8'hA5);
        run_conv(3'd7, 8'hFF, 8'h00);
        run_conv(3'd1, 8'h80, 8'hFF);
        run_conv(3'd4, 8'h7F, 8'h80);
        run_conv(3'd2, 8'h55, 8'h7F);
        run_conv(3'd5, 8'h01, 8'h55);

        // R10: restart mid-conversion
        vin[2] = 8'h3C;
        vin[5] = 8'hC3;
        wr_ctrl(8'h12, wa);
        wait_cnt(wa + 20);
        wr_ctrl(8'h15, wb);
        q.push_back('{val: 8'hC3, due: wb + CONV});
        wait_cnt(wa + CONV + 1);
        rd(1'b0, r);
        chk(r[3] == 1'b0 && irq == 1'b0, "R10 no completion at old due", {r[3], irq}, 0);
        rd(1'b1, r);
        chk(r == 8'h01, "R10 data unchanged at old due", r, 8'h01);
        wait_cnt(wb + CONV + 1);
        rd(1'b0, r);
        chk(r[3] == 1'b1, "R10 flag after restarted window", r[3], 1);
        ack_irq();

        // R11: flag-set write during a conversion
        vin[6] = 8'h6A;
        wr_ctrl(8'h16, wa);
        q.push_back('{val: 8'h6A, due: wa + CONV});
        wait_cnt(wa + 10);
        wr_ctrl(8'h1E, wb);
        rd(1'b0, r);
        chk(r == 8'h16, "R11 fields updated, flag still low", r, 8'h16);
        wait_cnt(wa + CONV - 1);
        rd(1'b0, r);
        chk(r[3] == 1'b0, "R11 conversion not stopped", r[3], 0);
        wait_cnt(wa + CONV + 1);
        rd(1'b0, r);
        chk(r[3] == 1'b1 && irq == 1'b1, "R11 completes on original window", {r[3], irq}, 2'b11);
        ack_irq();

        repeat (5) @(negedge clk);
        chk(q.size() == 0, "R5 all expected completions seen", q.size(), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule